// File: doc/BRIEF.md
# Programmable Divided Clock Output

This block takes a base clock and makes two outputs from it. The first output is the base clock itself, behind an enable. The second output is a divided clock, also behind its own enable. The divided clock is set by an 8-bit divide value `n` and a mode bit.

With the mode bit low, the block divides by `n + 1` and gives a narrow pulse that is high for one base cycle. The one exception is `n = 0`: there the base clock is passed straight through. With the mode bit high, the block divides by `2(n + 1)` and the output is a square wave with a 50% duty cycle.

A down-counter reloads from the divide input each time it reaches zero. A new divide value or mode is taken in only at that reload, so a setting change never cuts a period short. When an enable is off, that output is driven low.

Top module: `div_clk_out`

## Requirements
- R1: With the mode bit at 0 and `n` between 1 and 255, the divided output has a period of `n + 1` base cycles and is high for exactly one base cycle in each period.
- R2: With the mode bit at 1, the divided output has a period of `2(n + 1)` base cycles and is high for `n + 1` of them.
- R3: With the mode bit at 0 and `n = 0`, the divided output equals the base clock: it is high while the base clock is high and low while the base clock is low.
- R4: At `n = 255`, the period is 256 cycles in mode 0 and 512 cycles in mode 1.
- R5: `clk_base_o` follows the base clock while `base_en` is 1 and is held low while `base_en` is 0.
- R6: `clk_div_o` is held low while `div_en` is 0, whatever the divide setting.
- R7: A change of `div_n` or `half_mode` takes effect only when the counter reloads. The period that is running completes at its old length, and later periods use the new setting.
- R8: While `rst_n` is low, the active setting is mode 0 with `n = 0`, so `clk_div_o` follows the base clock, gated by `div_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_n | input | 8 | Divide value `n` |
| half_mode | input | 1 | 1: divide by `2(n+1)` with 50% duty; 0: divide by `n+1` with a one-cycle pulse |
| base_en | input | 1 | Enable for the base clock output |
| div_en | input | 1 | Enable for the divided output |
| clk_base_o | output | 1 | Gated base clock |
| clk_div_o | output | 1 | Gated divided clock |

## Verification
The bench changes the divide value partway through a long period. A design that loads the new value at once would give a short period here, where the correct design completes the old period first.

It also runs `n = 0` in both modes. Mode 0 must pass the base clock through, and mode 1 must give a divide-by-2. A design that missed the bypass would hold the output steady in mode 0.

At `n = 255`, any loss of the top counter bit shows up as a wrong period.

Each enable is switched off while its output is running. A design that parked a disabled output at its last level instead of low would fail this check.

// File: rtl/div_clk_out.sv
module div_clk_out #(
  parameter int DIV_W = 8
) (
  input  logic             clk_base,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_n,
  input  logic             half_mode,
  input  logic             base_en,
  input  logic             div_en,
  output logic             clk_base_o,
  output logic             clk_div_o
);

  logic [DIV_W-1:0] cnt_q, act_n_q, cnt_nx;
  logic             act_mode_q, pulse_q, tog_q;
  logic             wrap, bypass, div_raw;

  assign wrap   = (cnt_q == '0);
  assign cnt_nx = wrap ? div_n : cnt_q - 1'b1;

  always_ff @(posedge clk_base or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      act_n_q    <= '0;
      act_mode_q <= 1'b0;
      pulse_q    <= 1'b1;
      tog_q      <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      pulse_q <= (cnt_nx == '0);
      if (wrap) begin
        act_n_q    <= div_n;
        act_mode_q <= half_mode;
        tog_q      <= half_mode & ~tog_q;
      end
    end
  end

  assign bypass     = !act_mode_q && (act_n_q == '0);
  assign div_raw    = bypass ? clk_base : (act_mode_q ? tog_q : pulse_q);
  assign clk_div_o  = div_en & div_raw;
  assign clk_base_o = base_en & clk_base;

endmodule

module div_clk_out_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             base_en,
  input logic             div_en,
  input logic             clk_base_o,
  input logic             clk_div_o,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] act_n,
  input logic             act_mode,
  input logic             tog
);

  // R6
  div_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_en |-> !clk_div_o);

  // R5
  base_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !base_en |-> !clk_base_o);

  // R7
  hold_setting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> ($stable(act_n) && $stable(act_mode)));

  // R1
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R2
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode && cnt != '0) |=> $stable(tog));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_n);

endmodule

bind div_clk_out div_clk_out_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk_base), .rst_n(rst_n), .base_en(base_en), .div_en(div_en),
  .clk_base_o(clk_base_o), .clk_div_o(clk_div_o), .cnt(cnt_q),
  .act_n(act_n_q), .act_mode(act_mode_q), .tog(tog_q));

// File: tb/div_clk_out_bench.sv
module div_clk_out_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_n = 8'd0;
  logic       half_mode = 1'b0;
  logic       base_en = 1'b1;
  logic       div_en = 1'b1;
  logic       clk_base_o, clk_div_o;
  int         tests = 0;
  int         fails = 0;

  always #(PERIOD/2) clk = ~clk;

  div_clk_out u_div_clk_out (
    .clk_base(clk), .rst_n(rst_n), .div_n(div_n), .half_mode(half_mode),
    .base_en(base_en), .div_en(div_en),
    .clk_base_o(clk_base_o), .clk_div_o(clk_div_o));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int per, output int hi);
    logic prev, cur;
    int guard;
    guard = 0;
    @(negedge clk); prev = clk_div_o;
    while (guard < 3000) begin
      @(negedge clk); cur = clk_div_o; guard++;
      if (!prev && cur) break;
      prev = cur;
    end
    per = 1; hi = 1; prev = 1'b1; guard = 0;
    while (guard < 3000) begin
      @(negedge clk); cur = clk_div_o; guard++;
      if (!prev && cur) break;
      per++;
      if (cur) hi++;
      prev = cur;
    end
  endtask

  task automatic set_and_measure(input logic [7:0] n, input logic m,
                                 output int per, output int hi);
    @(negedge clk); div_n = n; half_mode = m;
    measure(per, hi);
    measure(per, hi);
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    check("R8 div follows high base in reset", clk_div_o, 1);
    @(negedge clk); #1;
    check("R8 div follows low base in reset", clk_div_o, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_mode0();
    int per, hi;
    set_and_measure(8'd3, 1'b0, per, hi);
    check("R1 period n=3", per, 4); check("R1 high n=3", hi, 1);
    set_and_measure(8'd1, 1'b0, per, hi);
    check("R1 period n=1", per, 2); check("R1 high n=1", hi, 1);
    set_and_measure(8'd6, 1'b0, per, hi);
    check("R1 period n=6", per, 7); check("R1 high n=6", hi, 1);
  endtask

  task automatic t_mode1();
    int per, hi;
    set_and_measure(8'd3, 1'b1, per, hi);
    check("R2 period n=3", per, 8); check("R2 high n=3", hi, 4);
    set_and_measure(8'd0, 1'b1, per, hi);
    check("R2 period n=0", per, 2); check("R2 high n=0", hi, 1);
  endtask

  task automatic t_bypass();
    @(negedge clk); div_n = 8'd0; half_mode = 1'b0;
    repeat (4) @(posedge clk);
    #1 check("R3 bypass high phase", clk_div_o, 1);
    @(negedge clk); #1 check("R3 bypass low phase", clk_div_o, 0);
  endtask

  task automatic t_max();
    int per, hi;
    set_and_measure(8'd255, 1'b0, per, hi);
    check("R4 mode0 period n=255", per, 256); check("R4 mode0 high", hi, 1);
    set_and_measure(8'd255, 1'b1, per, hi);
    check("R4 mode1 period n=255", per, 512); check("R4 mode1 high", hi, 256);
  endtask

  task automatic t_change();
    int per, hi, gap;
    set_and_measure(8'd7, 1'b0, per, hi);
    while (clk_div_o !== 1'b1) @(negedge clk);
    @(negedge clk);
    div_n = 8'd2;
    gap = 1;
    @(negedge clk);
    while (clk_div_o !== 1'b1 && gap < 50) begin @(negedge clk); gap++; end
    check("R7 running period keeps old length", gap, 7);
    measure(per, hi);
    check("R7 new period applied", per, 3);
  endtask

  task automatic t_enables();
    int ones;
    @(negedge clk); div_n = 8'd0; half_mode = 1'b1;
    repeat (4) @(negedge clk);
    base_en = 1'b0; div_en = 1'b0;
    ones = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1 if (clk_base_o || clk_div_o) ones++;
      @(negedge clk); #1 if (clk_base_o || clk_div_o) ones++;
    end
    check("R5 R6 disabled outputs low", ones, 0);
    base_en = 1'b1;
    @(posedge clk); #1 check("R5 base passes when enabled", clk_base_o, 1);
    @(negedge clk); #1 check("R5 base low phase", clk_base_o, 0);
    div_en = 1'b1;
    ones = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1 if (clk_div_o) ones++;
    end
    check("R6 divided output resumes", ones, 4);
  endtask

  initial begin
    t_reset();
    t_mode0();
    t_mode1();
    t_bypass();
    t_max();
    t_change();
    t_enables();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule